// File: doc/BRIEF.md
# Byte-Bus UART Register Bank with Divisor Bank Switch

This block is the host-facing register set of a classic serial port, together with a basic transmitter. A byte-wide bus selects one of eight register offsets. The block stores the line format register and a 16-bit baud divisor, and it reports transmitter status. A character written to the data offset goes into a one-entry holding register. From there it moves into a shift register, which sends it on `txd` as a frame with one start bit, eight data bits, no parity and one stop bit. With this framing every character takes ten bit times, so a 115200 baud line carries 11520 characters per second.

The two lowest offsets are shared. Bit 7 of the line format register is a bank switch. While it is set, offsets 0 and 1 reach the low and high divisor bytes. While it is clear, they reach the transmit data register and a plain interrupt-enable storage byte. Software sets the bank bit, writes the divisor, then clears the bank bit before it sends data.

The character path has no ready signal and the bus is not back-pressured. Software must poll the holding-empty status bit before each write. A character written while the holding register is occupied is discarded, so the character already queued is never overwritten. Receive logic, FIFOs, modem lines and interrupt identification are not implemented. The offsets that would hold them are plain storage or read as zero.

Top module: `uart_regbank_tx`

## Requirements
- R1: Offset 3 (line format), offset 4 and offset 7 are 8-bit read/write storage registers. Offset 1 is also 8-bit read/write storage while bank bit 7 of offset 3 is clear. Reads of offsets 2 and 6, and reads of offset 0 with the bank bit clear, return 0x00.
- R2: While bit 7 of offset 3 is set, offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes divisor bits 15:8.
- R3: With the bank bit set, writes to offsets 0 and 1 change neither the offset 1 storage byte nor the transmitter. With the bank bit clear, writes to offsets 0 and 1 leave the divisor unchanged.
- R4: Offset 5 is the line status register. Bit 5 is 1 when the holding register is empty. Bit 6 is 1 when both the holding register and the shift register are empty. All other bits read 0.
- R5: A write to offset 0 with the bank bit clear and the holding register empty makes status bit 5 read 0 in the next cycle. If the shifter is idle, the character moves into it one cycle later and status bit 5 reads 1 again.
- R6: A write to offset 0 while status bit 5 is 0 is discarded. No frame is ever sent for it.
- R7: `txd` idles at 1. A frame is a 0 start bit, then the eight data bits least significant bit first, then a 1 stop bit.
- R8: Each bit lasts 16 × divisor clock cycles. A divisor of 0 acts as 1.
- R9: After reset, offsets 1, 3, 4 and 7 hold 0x00, the divisor is 1, the line status reads 0x60 and `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the baud reference |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| txd | output | 1 | Serial transmit line |

## Verification
The hardest case to reach is a character arriving while the holding register is still full. This happens only when the shifter is already busy with one character and a second is queued behind it. A directed sequence at the smallest divisor creates it: write one character, wait two cycles for it to enter the shifter, write a second, then write a third at once. Only the first two may appear on the line. Random phases then vary the divisor and the data bytes while polling status bit 5. Each frame is decoded from `txd` at mid-bit, and the start-bit width is timed for divisors 0 and 3.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
  localparam int BYTE_W = 8;
  localparam int OFS_W  = 3;

  localparam logic [OFS_W-1:0] OFS_DATA = 3'd0;
  localparam logic [OFS_W-1:0] OFS_IEN  = 3'd1;
  localparam logic [OFS_W-1:0] OFS_ID   = 3'd2;
  localparam logic [OFS_W-1:0] OFS_FMT  = 3'd3;
  localparam logic [OFS_W-1:0] OFS_MCTL = 3'd4;
  localparam logic [OFS_W-1:0] OFS_STAT = 3'd5;
  localparam logic [OFS_W-1:0] OFS_MSTA = 3'd6;
  localparam logic [OFS_W-1:0] OFS_SCR  = 3'd7;

  localparam int FMT_BANK_BIT  = 7;
  localparam int STAT_HOLD_BIT = 5;
  localparam int STAT_IDLE_BIT = 6;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_START,
    TX_DATA,
    TX_STOP
  } tx_state_e;
endpackage

// File: rtl/uart_rb_regs.sv
module uart_rb_regs
  import uart_rb_pkg::*;
#(
  parameter int DATA_W    = BYTE_W,
  parameter int DIV_W     = 2 * BYTE_W,
  parameter int RESET_DIV = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [OFS_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              hold_full,
  input  logic              shift_busy,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bank_sel,
  output logic [DIV_W-1:0]  divisor,
  output logic              push,
  output logic [DATA_W-1:0] push_data
);
  localparam int NSTORE = 4;
  localparam logic [OFS_W-1:0] STORE_OFS [NSTORE] = '{OFS_IEN, OFS_FMT, OFS_MCTL, OFS_SCR};
  localparam int FMT_IDX = 1;
  localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(RESET_DIV);

  logic              wr;
  logic [DATA_W-1:0] store_q [NSTORE];
  logic [DATA_W-1:0] div_lo_q;
  logic [DATA_W-1:0] div_hi_q;
  logic [DATA_W-1:0] status;

  assign wr       = bus_en && bus_we;
  assign bank_sel = store_q[FMT_IDX][FMT_BANK_BIT];
  assign divisor  = {div_hi_q, div_lo_q};

  // Plain storage bytes; the one at offset 1 is hidden while the bank bit is set.
  for (genvar g = 0; g < NSTORE; g++) begin : g_store
    localparam bit SHARED = (STORE_OFS[g] == OFS_IEN);
    logic hit;
    assign hit = wr && (bus_addr == STORE_OFS[g]) && !(SHARED && bank_sel);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   store_q[g] <= '0;
      else if (hit) store_q[g] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_lo_q <= DIV_INIT[DATA_W-1:0];
      div_hi_q <= DIV_INIT[DIV_W-1:DATA_W];
    end else if (wr && bank_sel) begin
      if (bus_addr == OFS_DATA) div_lo_q <= bus_wdata;
      if (bus_addr == OFS_IEN)  div_hi_q <= bus_wdata;
    end
  end

  // Character push; a write that finds the holding register full is dropped.
  assign push      = wr && (bus_addr == OFS_DATA) && !bank_sel && !hold_full;
  assign push_data = bus_wdata;

  always_comb begin
    status = '0;
    status[STAT_HOLD_BIT] = !hold_full;
    status[STAT_IDLE_BIT] = !hold_full && !shift_busy;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_DATA: bus_rdata = bank_sel ? div_lo_q : '0;
      OFS_IEN:  bus_rdata = bank_sel ? div_hi_q : store_q[0];
      OFS_FMT:  bus_rdata = store_q[1];
      OFS_MCTL: bus_rdata = store_q[2];
      OFS_STAT: bus_rdata = status;
      OFS_SCR:  bus_rdata = store_q[3];
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_rb_baud.sv
module uart_rb_baud #(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] divisor,
  output logic             bit_end
);
  localparam int CNT_W = DIV_W + $clog2(OVS) + 1;

  logic [DIV_W-1:0] div_eff;
  logic [CNT_W-1:0] bit_len;
  logic [CNT_W-1:0] cnt_q;

  assign div_eff = (divisor == '0) ? DIV_W'(1) : divisor;
  assign bit_len = CNT_W'(div_eff) * CNT_W'(OVS);
  assign bit_end = run && (cnt_q == bit_len - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (restart || !run)  cnt_q <= '0;
    else if (bit_end)          cnt_q <= '0;
    else                       cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/uart_rb_tx.sv
module uart_rb_tx
  import uart_rb_pkg::*;
#(
  parameter int DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              bit_end,
  output logic              hold_full,
  output logic [DATA_W-1:0] hold_data,
  output logic              load,
  output logic              busy,
  output logic              txd
);
  localparam int IDX_W = $clog2(DATA_W);

  tx_state_e         state_q;
  logic [DATA_W-1:0] shreg_q;
  logic [IDX_W-1:0]  idx_q;

  assign load = hold_full && (state_q == TX_IDLE);
  assign busy = (state_q != TX_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (load) begin
      hold_full <= 1'b0;
    end else if (push) begin
      hold_full <= 1'b1;
      hold_data <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      shreg_q <= '0;
      idx_q   <= '0;
      txd     <= 1'b1;
    end else begin
      case (state_q)
        TX_IDLE: begin
          txd <= 1'b1;
          if (load) begin
            shreg_q <= hold_data;
            idx_q   <= '0;
            txd     <= 1'b0;
            state_q <= TX_START;
          end
        end
        TX_START: if (bit_end) begin
          txd     <= shreg_q[0];
          state_q <= TX_DATA;
        end
        TX_DATA: if (bit_end) begin
          if (idx_q == IDX_W'(DATA_W - 1)) begin
            txd     <= 1'b1;
            state_q <= TX_STOP;
          end else begin
            shreg_q <= shreg_q >> 1;
            txd     <= shreg_q[1];
            idx_q   <= idx_q + IDX_W'(1);
          end
        end
        TX_STOP: if (bit_end) begin
          state_q <= TX_IDLE;
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_regbank_tx.sv
module uart_regbank_tx
  import uart_rb_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int RESET_DIV  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              txd
);
  localparam int DATA_W = BYTE_W;
  localparam int DIV_W  = 2 * BYTE_W;

  logic              bank_sel;
  logic [DIV_W-1:0]  divisor;
  logic              push;
  logic [DATA_W-1:0] push_data;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              load;
  logic              busy;
  logic              bit_end;

  uart_rb_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W), .RESET_DIV(RESET_DIV)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .hold_full(hold_full),
    .shift_busy(busy), .bus_rdata(bus_rdata), .bank_sel(bank_sel),
    .divisor(divisor), .push(push), .push_data(push_data)
  );

  uart_rb_baud #(.DIV_W(DIV_W), .OVS(OVERSAMPLE)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(busy), .restart(load),
    .divisor(divisor), .bit_end(bit_end)
  );

  uart_rb_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
    .bit_end(bit_end), .hold_full(hold_full), .hold_data(hold_data),
    .load(load), .busy(busy), .txd(txd)
  );
endmodule

// File: rtl/uart_regbank_tx_chk.sv
module uart_regbank_tx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_en,
  input logic        bus_we,
  input logic [2:0]  bus_addr,
  input logic [7:0]  bus_rdata,
  input logic        txd,
  input logic        bank_sel,
  input logic [15:0] divisor,
  input logic        hold_full,
  input logic [7:0]  hold_data,
  input logic        busy
);
  logic data_wr;
  assign data_wr = bus_en && bus_we && (bus_addr == 3'd0) && !bank_sel;

  assert_div_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && !bank_sel && (bus_addr == 3'd0 || bus_addr == 3'd1)) |=> $stable(divisor));

  assert_stat_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd5) |-> (bus_rdata[4:0] == 5'd0 && !bus_rdata[7]));

  assert_hold_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !hold_full) |=> hold_full);

  assert_no_overwrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && hold_full) |=> $stable(hold_data));

  assert_idle_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  assert_start_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
endmodule

bind uart_regbank_tx uart_regbank_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .txd(txd),
  .bank_sel(bank_sel), .divisor(divisor), .hold_full(hold_full),
  .hold_data(hold_data), .busy(busy)
);

// File: tb/uart_regbank_tx_bench.sv
module uart_regbank_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_en = 1'b0;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       txd;

  int errors = 0;
  int checks = 0;
  int cur_len = 16;
  logic [7:0] exp_q [$];
  logic [7:0] got_q [$];

  always #2 clk = ~clk;

  uart_regbank_tx u_uart_regbank_tx (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .txd(txd)
  );

  function automatic int exp_len(input int div);
    return (div == 0 ? 1 : div) * 16;
  endfunction

  function automatic logic [7:0] exp_stat(input bit hold_empty, input bit all_empty);
    return {1'b0, all_empty, hold_empty, 5'b0};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic set_div(input int div);
    wr(3'd3, 8'h80);
    wr(3'd0, div[7:0]);
    wr(3'd1, div[15:8]);
    wr(3'd3, 8'h03);
    cur_len = exp_len(div);
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    forever begin
      rd(3'd5, s);
      if (s[6]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic send_polled(input logic [7:0] d);
    logic [7:0] s;
    forever begin
      rd(3'd5, s);
      if (s[5]) break;
    end
    wr(3'd0, d);
    exp_q.push_back(d);
  endtask

  task automatic compare_frames(input string req);
    while (exp_q.size() > 0) begin
      logic [7:0] e;
      e = exp_q.pop_front();
      if (got_q.size() == 0) check(1'b0, req, -1, e);
      else begin
        logic [7:0] g;
        g = got_q.pop_front();
        check(g == e, req, g, e);
      end
    end
    check(got_q.size() == 0, {req, " extra frames"}, got_q.size(), 0);
    got_q.delete();
  endtask

  // Line decoder: mid-bit sampling, R7 framing
  initial begin
    forever begin
      logic [7:0] b;
      @(negedge clk);
      if (rst_n && txd == 1'b0) begin
        repeat (cur_len / 2 - 1) @(negedge clk);
        check(txd == 1'b0, "R7 start bit", txd, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (cur_len) @(negedge clk);
          b[i] = txd;
        end
        repeat (cur_len) @(negedge clk);
        check(txd == 1'b1, "R7 stop bit", txd, 1);
        got_q.push_back(b);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    void'($urandom(32'h5EED1));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    check(txd == 1'b1, "R9 txd idle", txd, 1);
    rd(3'd5, v); check(v == 8'h60, "R9 status", v, 8'h60);
    rd(3'd3, v); check(v == 8'h00, "R9 format", v, 0);
    rd(3'd1, v); check(v == 8'h00, "R9 offset1", v, 0);
    rd(3'd7, v); check(v == 8'h00, "R9 scratch", v, 0);
    wr(3'd3, 8'h80);
    rd(3'd0, v); check(v == 8'h01, "R9 divisor low", v, 1);
    rd(3'd1, v); check(v == 8'h00, "R9 divisor high", v, 0);

    // R2 divisor bank access, R3 isolation
    wr(3'd0, 8'hA5); wr(3'd1, 8'h3C);
    rd(3'd0, v); check(v == 8'hA5, "R2 divisor low", v, 8'hA5);
    rd(3'd1, v); check(v == 8'h3C, "R2 divisor high", v, 8'h3C);
    rd(3'd5, v); check(v == exp_stat(1, 1), "R3 no tx from bank write", v, exp_stat(1, 1));
    wr(3'd3, 8'h03);
    rd(3'd1, v); check(v == 8'h00, "R3 offset1 untouched by bank write", v, 0);
    rd(3'd0, v); check(v == 8'h00, "R1 data offset reads zero", v, 0);
    wr(3'd1, 8'h5A);
    rd(3'd1, v); check(v == 8'h5A, "R1 offset1 storage", v, 8'h5A);
    wr(3'd3, 8'h83);
    rd(3'd1, v); check(v == 8'h3C, "R3 divisor high kept", v, 8'h3C);
    rd(3'd0, v); check(v == 8'hA5, "R3 divisor low kept", v, 8'hA5);
    wr(3'd3, 8'h03);

    // R1 storage with random patterns
    for (int i = 0; i < 6; i++) begin
      logic [7:0] a, c;
      a = 8'($urandom); c = 8'($urandom);
      wr(3'd4, a); wr(3'd7, c);
      rd(3'd4, v); check(v == a, "R1 offset4", v, a);
      rd(3'd7, v); check(v == c, "R1 offset7", v, c);
    end
    rd(3'd2, v); check(v == 8'h00, "R1 offset2 zero", v, 0);
    rd(3'd6, v); check(v == 8'h00, "R1 offset6 zero", v, 0);
    rd(3'd3, v); check(v == 8'h03, "R1 format readback", v, 3);

    // R5 status timing, R8 bit length with divisor 0 and 3
    for (int k = 0; k < 2; k++) begin
      int dv;
      dv = (k == 0) ? 0 : 3;
      set_div(dv);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h01;
      @(negedge clk);
      bus_we = 1'b0; bus_addr = 3'd5;
      #1 check(bus_rdata == exp_stat(0, 0), "R5 hold full after write", bus_rdata, exp_stat(0, 0));
      @(negedge clk);
      #1 check(bus_rdata == exp_stat(1, 0), "R5 hold empty after move", bus_rdata, exp_stat(1, 0));
      bus_en = 1'b0;
      exp_q.push_back(8'h01);
      while (txd) @(negedge clk);
      n = 0;
      while (!txd) begin n++; @(negedge clk); end
      check(n == exp_len(dv), "R8 start bit width", n, exp_len(dv));
      wait_idle();
      compare_frames("R7 frame 0x01");
    end

    // R6 drop while holding register full
    set_div(1);
    wr(3'd0, 8'hC3); exp_q.push_back(8'hC3);
    repeat (2) @(negedge clk);
    wr(3'd0, 8'h96); exp_q.push_back(8'h96);
    wr(3'd0, 8'h11);
    rd(3'd5, v); check(v == exp_stat(0, 0), "R6 holding still full", v, exp_stat(0, 0));
    wait_idle();
    compare_frames("R6 dropped write");

    // Random divisors and data, polled
    for (int r = 0; r < 3; r++) begin
      set_div(1 + int'($urandom % 3));
      for (int i = 0; i < 6; i++) send_polled(8'($urandom));
      send_polled(8'h00);
      send_polled(8'hFF);
      wait_idle();
      compare_frames("R7 random frames");
    end
    check(txd == 1'b1, "R7 idle after frames", txd, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule